// File: doc/BRIEF.md
# Chunked Outbound Address Window Decoder

This block decides, for every CPU-side address, whether the access goes out to the downstream PCI memory space. The upper 256 MiB of the 32-bit space, from 0xF000_0000 upward, is split into thirty-two 8 MiB chunks. Each chunk has its own bit in an enable register. A 2-bit mode field in a control register enables or disables all of them at once. The two outermost chunks never forward: chunk 0 holds firmware and chunk 31 holds the bridge's own registers.

The block also holds the reverse map used by downstream bus masters. It sorts each downstream address into one of four classes: system RAM, PCI memory, a 1 MiB window back into the CPU-local region, or unmapped. The block carries no data. Software writes the two configuration registers through a simple write port. The block turns them into a registered per-chunk gate map, and both address decoders are purely combinational.

Top module: `outbound_window_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), the enable bits and the mode field are zero, and fwd_hit is 0 for every cpu_addr until a configuration write takes effect.
- R2: Chunk i covers 0xF000_0000 + i·8 MiB through 0xF000_0000 + (i+1)·8 MiB − 1. An address in chunk i forwards (fwd_hit = 1) when enable bit i is set and forwarding is on.
- R3: Enable bit 0 and enable bit 31 are ignored. Addresses in 0xF000_0000–0xF07F_FFFF and 0xFF80_0000–0xFFFF_FFFF never forward.
- R4: Forwarding is on only while bits [8:7] of the last control write equal 2'b01. The values 00, 10 and 11 turn off every chunk, and all other control bits have no effect.
- R5: A write with cfg_wr_sel = 0 replaces the enable register, and a write with cfg_wr_sel = 1 replaces the control register. Each write leaves the other register unchanged. The gate map follows the new value from the first rising edge that samples the write, and never before it.
- R6: An address below 0xF000_0000 never forwards, whatever the configuration.
- R7: While fwd_hit is 1, fwd_chunk gives the chunk index, which is address bits [27:23]. While fwd_hit is 0, fwd_chunk is 0.
- R8: bm_region is 2'b01 (system RAM) for bm_addr from 0 up to 0xF07F_FFFF.
- R9: bm_region is 2'b10 (PCI memory) for bm_addr from 0xF080_0000 through 0xFF7F_FFFF.
- R10: bm_region is 2'b11 (CPU-local window) for bm_addr from 0xFFF0_0000 through 0xFFFF_FFFF.
- R11: bm_region is 2'b00 (unmapped) for bm_addr from 0xFF80_0000 through 0xFFEF_FFFF.
- R12: bm_region depends on bm_addr alone. The configuration registers do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0 selects the enable register, 1 selects the control register |
| cfg_wr_data | input | 32 | Write data |
| cpu_addr | input | 32 | CPU-side address to decode |
| fwd_hit | output | 1 | Access is forwarded downstream |
| fwd_chunk | output | 5 | Index of the forwarded chunk, 0 on a miss |
| bm_addr | input | 32 | Downstream bus-master address to classify |
| bm_region | output | 2 | Region code: 00 unmapped, 01 RAM, 10 PCI memory, 11 CPU-local |

## Verification
Both decoders are combinational. The bench therefore changes cpu_addr or bm_addr on a falling edge and compares fwd_hit, fwd_chunk and bm_region one time unit later, in the same low phase. A configuration write has a latency of one edge. The bench presents the write on a falling edge and checks that a probe in that same low phase still sees the old gate map. It then checks the new map at the following falling edge. It never samples in between. For R5 the bench uses this to show both the exact cycle of the change and that the untouched register keeps its value. The sweeps cover the first, second, middle and last byte of all 32 chunks under walking-one and dense enable patterns and under every mode value. The bus-master sweep steps through the whole 4 GiB space in 4 MiB strides and adds each boundary byte, under two different configurations.

// File: rtl/owd_pkg.sv
// Shared constants and types for the outbound window decoder.
// Assumes a 32-bit address space; register selects are a single bit.
package owd_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int MODE_LSB = 7;

    localparam logic       SEL_ENABLE  = 1'b0;
    localparam logic       SEL_CONTROL = 1'b1;
    localparam logic [1:0] MODE_FWD    = 2'b01;

    typedef enum logic [1:0] {
        RGN_UNMAPPED = 2'b00,
        RGN_SYSRAM   = 2'b01,
        RGN_PCIMEM   = 2'b10,
        RGN_CPULOCAL = 2'b11
    } region_e;

endpackage

// File: rtl/owd_cfg_regs.sv
// Configuration registers and gate map.
// Holds the chunk enable register and the 2-bit mode field. On every write
// it recomputes a registered per-chunk gate map from the post-write values,
// forcing the first and last chunk closed. Assumes CHUNK_CNT <= DATA_W.
module owd_cfg_regs
    import owd_pkg::*;
#(
    parameter int CHUNK_CNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [CHUNK_CNT-1:0] chunk_open
);

    logic [CHUNK_CNT-1:0] en_q;
    logic [CHUNK_CNT-1:0] en_d;
    logic [1:0]           mode_q;
    logic [1:0]           mode_d;
    logic                 fwd_on;
    logic [CHUNK_CNT-1:0] gated;
    logic                 unused_data;
    logic                 unused_edge;

    // Next register values: the selected register takes the write data.
    always_comb begin
        en_d   = en_q;
        mode_d = mode_q;
        if (wr_en) begin
            if (wr_sel == SEL_CONTROL) begin
                mode_d = wr_data[MODE_LSB +: 2];
            end else begin
                en_d = wr_data[CHUNK_CNT-1:0];
            end
        end
    end

    assign fwd_on = (mode_d == MODE_FWD);

    // Per-chunk gate: outermost chunks are hard-closed.
    for (genvar gi = 0; gi < CHUNK_CNT; gi++) begin : g_gate
        if (gi == 0 || gi == CHUNK_CNT - 1) begin : g_closed
            assign gated[gi] = 1'b0;
        end else begin : g_open
            assign gated[gi] = en_d[gi] & fwd_on;
        end
    end

    assign unused_data = ^wr_data;
    assign unused_edge = en_d[0] ^ en_d[CHUNK_CNT-1];

    // Register update and gate-map recompute on any configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= '0;
            mode_q     <= '0;
            chunk_open <= '0;
        end else if (wr_en) begin
            en_q       <= en_d;
            mode_q     <= mode_d;
            chunk_open <= gated;
        end
    end

endmodule

// File: rtl/owd_cpu_decode.sv
// CPU-side forward decoder (combinational).
// Computes the chunk index of cpu_addr relative to WIN_BASE and looks it up
// in the gate map. Assumes CHUNK_LG2 < ADDR_W.
module owd_cpu_decode
    import owd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'hF000_0000,
    parameter int                CHUNK_LG2 = 23,
    parameter int                CHUNK_CNT = 32,
    localparam int               IDX_W     = $clog2(CHUNK_CNT)
) (
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [CHUNK_CNT-1:0] chunk_open,
    output logic                 fwd_hit,
    output logic [IDX_W-1:0]     fwd_chunk
);

    localparam int HI_W = ADDR_W - CHUNK_LG2;

    logic [ADDR_W-1:0]    offset;
    logic                 in_win;
    logic                 in_span;
    logic [HI_W-1:0]      idx_full;
    logic [CHUNK_CNT-1:0] sel;
    logic                 unused_low;

    // Offset into the window and the chunk number it falls in.
    assign offset   = cpu_addr - WIN_BASE;
    assign in_win   = (cpu_addr >= WIN_BASE);
    assign idx_full = offset[ADDR_W-1:CHUNK_LG2];
    assign in_span  = in_win && (idx_full < HI_W'(CHUNK_CNT));

    // One-hot chunk select.
    for (genvar gi = 0; gi < CHUNK_CNT; gi++) begin : g_sel
        assign sel[gi] = in_span && (idx_full == HI_W'(gi));
    end

    assign fwd_hit    = |(sel & chunk_open);
    assign fwd_chunk  = fwd_hit ? idx_full[IDX_W-1:0] : '0;
    assign unused_low = ^offset[CHUNK_LG2-1:0];

endmodule

// File: rtl/owd_bm_decode.sv
// Bus-master region classifier (combinational).
// Sorts a downstream address into RAM below the first forwardable chunk,
// PCI memory over the forwardable chunks, a CPU-local window, or unmapped.
// Comparisons are done one bit wider so a window ending at 2^ADDR_W works.
module owd_bm_decode
    import owd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'hF000_0000,
    parameter int                CHUNK_LG2  = 23,
    parameter int                CHUNK_CNT  = 32,
    parameter logic [ADDR_W-1:0] LOCAL_BASE = 32'hFFF0_0000,
    parameter int                LOCAL_LG2  = 20
) (
    input  logic [ADDR_W-1:0] bm_addr,
    output region_e           bm_region
);

    typedef logic [ADDR_W:0] wide_t;

    localparam wide_t PCI_LO = {1'b0, WIN_BASE} + (wide_t'(1) << CHUNK_LG2);
    localparam wide_t PCI_HI = {1'b0, WIN_BASE} + (wide_t'(CHUNK_CNT - 1) << CHUNK_LG2);
    localparam wide_t LOC_LO = {1'b0, LOCAL_BASE};
    localparam wide_t LOC_HI = LOC_LO + (wide_t'(1) << LOCAL_LG2);

    wide_t a;

    assign a = {1'b0, bm_addr};

    // Range classification, lowest region first.
    always_comb begin
        if (a < PCI_LO) begin
            bm_region = RGN_SYSRAM;
        end else if (a < PCI_HI) begin
            bm_region = RGN_PCIMEM;
        end else if (a >= LOC_LO && a < LOC_HI) begin
            bm_region = RGN_CPULOCAL;
        end else begin
            bm_region = RGN_UNMAPPED;
        end
    end

endmodule

// File: rtl/outbound_window_decoder.sv
// Top level of the chunked outbound window decoder.
// Connects the configuration registers to the CPU-side decoder and holds
// the independent bus-master classifier. Configuration writes take effect
// one edge later; both decoders are combinational.
module outbound_window_decoder
    import owd_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'hF000_0000,
    parameter int          CHUNK_LG2  = 23,
    parameter int          CHUNK_CNT  = 32,
    parameter logic [31:0] LOCAL_BASE = 32'hFFF0_0000,
    parameter int          LOCAL_LG2  = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr_en,
    input  logic                         cfg_wr_sel,
    input  logic [31:0]                  cfg_wr_data,
    input  logic [31:0]                  cpu_addr,
    output logic                         fwd_hit,
    output logic [$clog2(CHUNK_CNT)-1:0] fwd_chunk,
    input  logic [31:0]                  bm_addr,
    output logic [1:0]                   bm_region
);

    logic [CHUNK_CNT-1:0] chunk_open;
    region_e              region;

    owd_cfg_regs #(
        .CHUNK_CNT (CHUNK_CNT)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_data    (cfg_wr_data),
        .chunk_open (chunk_open)
    );

    owd_cpu_decode #(
        .WIN_BASE  (WIN_BASE),
        .CHUNK_LG2 (CHUNK_LG2),
        .CHUNK_CNT (CHUNK_CNT)
    ) u_cpu (
        .cpu_addr   (cpu_addr),
        .chunk_open (chunk_open),
        .fwd_hit    (fwd_hit),
        .fwd_chunk  (fwd_chunk)
    );

    owd_bm_decode #(
        .WIN_BASE   (WIN_BASE),
        .CHUNK_LG2  (CHUNK_LG2),
        .CHUNK_CNT  (CHUNK_CNT),
        .LOCAL_BASE (LOCAL_BASE),
        .LOCAL_LG2  (LOCAL_LG2)
    ) u_bm (
        .bm_addr   (bm_addr),
        .bm_region (region)
    );

    assign bm_region = region;

endmodule

// File: rtl/owd_checker.sv
// Property checker for outbound_window_decoder, attached by bind.
// Keeps its own shadow of the configuration writes and checks the decoder
// outputs against it and against the address ranges.
module owd_checker
    import owd_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'hF000_0000,
    parameter int          CHUNK_LG2  = 23,
    parameter int          CHUNK_CNT  = 32,
    parameter logic [31:0] LOCAL_BASE = 32'hFFF0_0000,
    parameter int          LOCAL_LG2  = 20,
    localparam int         IDX_W      = $clog2(CHUNK_CNT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic             cfg_wr_sel,
    input logic [31:0]      cfg_wr_data,
    input logic [31:0]      cpu_addr,
    input logic             fwd_hit,
    input logic [IDX_W-1:0] fwd_chunk,
    input logic [31:0]      bm_addr,
    input logic [1:0]       bm_region
);

    typedef logic [32:0] wide_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_CNT - 1);
    localparam wide_t RAM_END = {1'b0, WIN_BASE} + (wide_t'(1) << CHUNK_LG2);
    localparam wide_t PCI_END = {1'b0, WIN_BASE} + (wide_t'(CHUNK_CNT - 1) << CHUNK_LG2);

    logic [CHUNK_CNT-1:0] en_sh;
    logic [1:0]           mode_sh;
    logic [31:0]          off;
    logic                 unused_chk;

    assign off        = cpu_addr - WIN_BASE;
    assign unused_chk = ^{off, cfg_wr_data};

    // Shadow of the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_sh   <= '0;
            mode_sh <= '0;
        end else if (cfg_wr_en) begin
            if (cfg_wr_sel) mode_sh <= cfg_wr_data[MODE_LSB +: 2];
            else            en_sh   <= cfg_wr_data[CHUNK_CNT-1:0];
        end
    end

    // R1
    reset_clears_hit_chk: assert property (@(posedge clk) !rst_n |=> !fwd_hit);

    // R3
    edge_chunk_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> (fwd_chunk != '0 && fwd_chunk != LAST_IDX));

    // R4
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> mode_sh == MODE_FWD);

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> en_sh[fwd_chunk]);

    // R2
    hit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> (cpu_addr >= WIN_BASE && off[CHUNK_LG2 +: IDX_W] == fwd_chunk));

    // R7
    miss_chunk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_hit |-> fwd_chunk == '0);

    // R8
    ram_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, bm_addr} < RAM_END) |-> bm_region == 2'b01);

    // R11
    unmapped_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_region == 2'b00) |-> ({1'b0, bm_addr} >= PCI_END && bm_addr < LOCAL_BASE));

endmodule

bind outbound_window_decoder owd_checker #(
    .WIN_BASE   (WIN_BASE),
    .CHUNK_LG2  (CHUNK_LG2),
    .CHUNK_CNT  (CHUNK_CNT),
    .LOCAL_BASE (LOCAL_BASE),
    .LOCAL_LG2  (LOCAL_LG2)
) u_owd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_sel  (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data),
    .cpu_addr    (cpu_addr),
    .fwd_hit     (fwd_hit),
    .fwd_chunk   (fwd_chunk),
    .bm_addr     (bm_addr),
    .bm_region   (bm_region)
);

// File: tb/tb_outbound_window_decoder.sv
// Sweep bench: expected values come from address arithmetic only.
module tb_outbound_window_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic        cfg_wr_sel;
    logic [31:0] cfg_wr_data;
    logic [31:0] cpu_addr;
    logic        fwd_hit;
    logic [4:0]  fwd_chunk;
    logic [31:0] bm_addr;
    logic [1:0]  bm_region;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Bench-side model of the configuration
    logic [31:0] m_en;
    logic        m_on;

    always #(CLK_PERIOD/2) clk = ~clk;

    outbound_window_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .cpu_addr    (cpu_addr),
        .fwd_hit     (fwd_hit),
        .fwd_chunk   (fwd_chunk),
        .bm_addr     (bm_addr),
        .bm_region   (bm_region)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = sel;
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        if (sel) m_on = (data[8:7] == 2'b01);
        else     m_en = data;
    endtask

    // Expected forward result from the chunk arithmetic.
    task automatic probe_cpu(input logic [31:0] addr, input string tag);
        logic [32:0] a;
        logic [31:0] idx;
        logic        eh;
        logic [4:0]  ec;
        @(negedge clk);
        cpu_addr = addr;
        #1;
        a  = {1'b0, addr};
        eh = 1'b0;
        ec = 5'd0;
        if (a >= 33'h0_F080_0000 && a < 33'h0_FF80_0000) begin
            idx = (addr - 32'hF000_0000) / 32'h0080_0000;
            if (m_on && m_en[idx]) begin
                eh = 1'b1;
                ec = idx[4:0];
            end
        end
        check(fwd_hit == eh, tag, $sformatf("hit @%h", addr), {31'd0, fwd_hit}, {31'd0, eh});
        check(fwd_chunk == ec, "R7", $sformatf("chunk @%h", addr), {27'd0, fwd_chunk}, {27'd0, ec});
    endtask

    task automatic sweep_chunks(input string tag);
        for (int c = 0; c < 32; c++) begin
            logic [31:0] s;
            s = 32'hF000_0000 + c * 32'h0080_0000;
            probe_cpu(s, tag);
            probe_cpu(s + 32'd1, tag);
            probe_cpu(s + 32'h0040_0000, tag);
            probe_cpu(s + 32'h007F_FFFF, tag);
        end
    endtask

    task automatic probe_bm(input logic [31:0] addr, input string tag);
        logic [32:0] a;
        logic [1:0]  er;
        @(negedge clk);
        bm_addr = addr;
        #1;
        a = {1'b0, addr};
        if (a < 33'h0_F080_0000)       er = 2'b01;
        else if (a < 33'h0_FF80_0000)  er = 2'b10;
        else if (a >= 33'h0_FFF0_0000) er = 2'b11;
        else                           er = 2'b00;
        check(bm_region == er, tag, $sformatf("region @%h", addr), {30'd0, bm_region}, {30'd0, er});
    endtask

    task automatic sweep_bm(input string tag);
        probe_bm(32'h0000_0000, "R8");
        probe_bm(32'hF07F_FFFF, "R8");
        probe_bm(32'hF080_0000, "R9");
        probe_bm(32'hFF7F_FFFF, "R9");
        probe_bm(32'hFF80_0000, "R11");
        probe_bm(32'hFFEF_FFFF, "R11");
        probe_bm(32'hFFF0_0000, "R10");
        probe_bm(32'hFFFF_FFFF, "R10");
        for (int k = 0; k < 1024; k++) begin
            probe_bm(k * 32'h0040_0000 + 32'h0001_2340, tag);
        end
    endtask

    initial begin
        rst_n       = 1'b0;
        cfg_wr_en   = 1'b0;
        cfg_wr_sel  = 1'b0;
        cfg_wr_data = '0;
        cpu_addr    = '0;
        bm_addr     = '0;
        m_en        = '0;
        m_on        = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing forwards
        sweep_chunks("R1");
        // R12: classification with reset configuration
        sweep_bm("R12");

        // R3 R2: everything enabled, mode on
        cfg_write(1'b1, 32'h0000_0080);
        cfg_write(1'b0, 32'hFFFF_FFFF);
        sweep_chunks("R3");
        // R12: classification unaffected by open configuration
        sweep_bm("R12");

        // R2: walking single enable bit
        for (int b = 0; b < 32; b++) begin
            cfg_write(1'b0, 32'h1 << b);
            sweep_chunks("R2");
        end
        cfg_write(1'b0, 32'hAAAA_AAAA);
        sweep_chunks("R2");
        cfg_write(1'b0, 32'h5555_5555);
        sweep_chunks("R2");
        cfg_write(1'b0, 32'h8000_0001);
        sweep_chunks("R3");

        // R6: addresses below the window
        cfg_write(1'b0, 32'hFFFF_FFFF);
        probe_cpu(32'h0000_0000, "R6");
        probe_cpu(32'h7800_0000, "R6");
        probe_cpu(32'hEFFF_FFFF, "R6");

        // R4: each mode value, other control bits toggled
        cfg_write(1'b1, 32'h0000_0000); sweep_chunks("R4");
        cfg_write(1'b1, 32'h0000_0100); sweep_chunks("R4");
        cfg_write(1'b1, 32'h0000_0180); sweep_chunks("R4");
        cfg_write(1'b1, 32'hFFFF_FE7F); sweep_chunks("R4");
        cfg_write(1'b1, 32'hFFFF_FEFF); sweep_chunks("R4");

        // R5: latency of one edge and independence of the two registers
        cfg_write(1'b1, 32'h0000_0000);
        cfg_write(1'b0, 32'h0000_0020);
        probe_cpu(32'hF280_0000, "R5");
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = 1'b1;
        cfg_wr_data = 32'h0000_0080;
        cpu_addr    = 32'hF280_0000;
        #1;
        check(fwd_hit == 1'b0, "R5", "hit before write edge", {31'd0, fwd_hit}, 32'd0);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_on      = 1'b1;
        #1;
        check(fwd_hit == 1'b1, "R5", "hit after write edge", {31'd0, fwd_hit}, 32'd1);
        probe_cpu(32'hF300_0000, "R5");
        cfg_write(1'b0, 32'h0000_0040);
        probe_cpu(32'hF300_0000, "R5");
        probe_cpu(32'hF280_0000, "R5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule